// File: doc/BRIEF.md
# Clock Domain Source Selector and Wait/Hold Divider

This block produces the clock for one clock domain of a chip. It picks one of five free-running input clocks (a slow real-time clock, a crystal oscillator and three PLL outputs) through a handover circuit that never shortens a pulse. It then divides the chosen clock with separate high-time and low-time counts, or passes it straight through when bypass is set.

Software drives the block through one 32-bit configuration word on a simple synchronous write port, with combinational read-back. A change of source raises a busy flag until the new clock really drives the domain. New divider counts are held back until software sets a request bit. That bit clears by itself once the divider has taken the counts at a period boundary.

Two parameters select variants. `CNT_W` narrows the count fields from 4 to 3 bits. `FIXED_SRC` ties the domain to source 4 permanently.

The design has three state machines:
- The source FSM (`clk` domain) moves from `SEL_STEADY` to `SEL_SWITCH` on an accepted write that changes the selection. It returns to `SEL_STEADY` when the synchronised gate status matches the new one-hot target.
- The update FSM (`clk` domain) moves from `UPD_IDLE` to `UPD_REQ` on a write with the request bit set. It moves from `UPD_REQ` to `UPD_DRAIN` when the divider's acknowledge arrives, and from `UPD_DRAIN` back to `UPD_IDLE` when the acknowledge drops.
- The phase FSM (divided clock domain) moves from `PH_HIGH` to `PH_LOW` after `wait`+1 source cycles. It moves from `PH_LOW` to `PH_HIGH` after `hold`+1 source cycles; that transition ends a period and is the only place a pending update is loaded.

Top module: `clk_domain_gen`

## Requirements
- R1: After reset the configuration word reads 0x0100_0001: source 1, bypass (bit 24) set, wait count (bits 19:16) 0, hold count (bits 23:20) 0, source-busy (bit 3) 0, update-busy (bit 25) 0.
- R2: A write whose select field (bits 2:0) is 5, 6 or 7 leaves the selection unchanged; the other fields of that write still apply.
- R3: A write that changes the select field makes bit 3 read 1 from the next cycle. Bit 3 returns to 0 once the new source drives the domain, and the output then follows the new source.
- R4: With bypass clear, the output is high for wait+1 and low for hold+1 cycles of the selected source. This gives ratios from 2 (both counts 0) to 32 (both counts 15).
- R5: With bit 24 set, the output equals the selected source clock.
- R6: Writing 1 to bit 25 makes bit 25 read 1 from the next cycle. Bit 25 clears by itself after the divider has adopted the written counts.
- R7: Counts written without bit 25 do not change the output period. A requested update takes effect only at the end of a complete low phase.
- R8: The split wait = R/2−1, hold = R−wait−2 of an even ratio R gives equal high and low times.
- R9: With `CNT_W`=3 the count fields keep only their 3 low bits. The unused upper bit of each field reads 0, limiting the ratio to 16.
- R10: With `FIXED_SRC`=1 the select field always reads 4, writes to it have no effect, and the output is derived from source 4.
- R11: At no time are two source gates open together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-port clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| src_clk | input | 5 | Candidate clocks: 0 RTC, 1 oscillator, 2..4 PLL outputs |
| reg_we | input | 1 | Write strobe for the configuration word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current configuration and busy flags |
| clk_out | output | 1 | Domain clock |

## Verification
The divider is tried with an asymmetric split (3 high / 5 low), an even split (6/6), the minimum ratio on the slowest source, and the maximum ratio on a fast source. Together these separate a swapped wait/hold mapping, an off-by-one in either phase, and counter wrap at the field limit. A counts-only write followed by a measurement of the unchanged period tells the deferred update apart from an immediate one. An invalid select write and a fixed-source write are judged by the read-back and by the period still measured on the expected source. The narrow-field instance shows masking of the upper count bit.

// File: rtl/clkdmn_pkg.sv
package clkdmn_pkg;
    localparam int NUM_SRC   = 5;
    localparam int SEL_W     = 3;
    localparam int FLD_W     = 4;
    localparam int SEL_LSB   = 0;
    localparam int SBUSY_BIT = 3;
    localparam int WAIT_LSB  = 16;
    localparam int HOLD_LSB  = 20;
    localparam int BYP_BIT   = 24;
    localparam int UPD_BIT   = 25;
    localparam int FIX_SEL   = 4;
    localparam int DEF_SEL   = 1;

    typedef enum logic       {SEL_STEADY, SEL_SWITCH}        sel_state_t;
    typedef enum logic [1:0] {UPD_IDLE, UPD_REQ, UPD_DRAIN}  upd_state_t;
    typedef enum logic       {PH_HIGH, PH_LOW}               phase_t;
endpackage

// File: rtl/clkdmn_gate_cell.sv
module clkdmn_gate_cell #(
    parameter bit RST_ON = 1'b0
) (
    input  logic src_clk,
    input  logic rst_n,
    input  logic want,
    input  logic others_on,
    output logic on,
    output logic gclk
);
    logic s1_q, s2_q;

    // Two flops on the falling edge of the own clock: the enable only moves
    // while this clock is low, so the gated clock never gets a short pulse.
    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST_ON;
            s2_q <= RST_ON;
        end else begin
            s1_q <= want & ~others_on;
            s2_q <= s1_q;
        end
    end

    assign on   = s2_q;
    assign gclk = src_clk & s2_q;
endmodule

// File: rtl/clkdmn_src_switch.sv
module clkdmn_src_switch #(
    parameter int NSRC    = 5,
    parameter int RST_SEL = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_clk,
    input  logic [NSRC-1:0] tgt_oh,
    output logic            mclk,
    output logic [NSRC-1:0] status_s
);
    localparam logic [NSRC-1:0] RST_OH = NSRC'(1) << RST_SEL;

    logic [NSRC-1:0] on;
    logic [NSRC-1:0] gclk;
    logic [NSRC-1:0] others;
    logic [NSRC-1:0] st1_q, st2_q;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_cell
            localparam logic [NSRC-1:0] SELF = NSRC'(1) << i;
            assign others[i] = |(on & ~SELF);
            clkdmn_gate_cell #(.RST_ON(RST_OH[i])) u_cell (
                .src_clk  (src_clk[i]),
                .rst_n    (rst_n),
                .want     (tgt_oh[i]),
                .others_on(others[i]),
                .on       (on[i]),
                .gclk     (gclk[i])
            );
        end
    endgenerate

    assign mclk = |gclk;

    // Bring the gate status back to the register clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st1_q <= RST_OH;
            st2_q <= RST_OH;
        end else begin
            st1_q <= on;
            st2_q <= st1_q;
        end
    end

    assign status_s = st2_q;

    // R11
    single_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(on));
endmodule

// File: rtl/clkdmn_divider.sv
module clkdmn_divider
    import clkdmn_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             mclk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_wait,
    input  logic [CNT_W-1:0] cfg_hold,
    input  logic             cfg_byp,
    input  logic             upd_req,
    output logic             upd_ack,
    output logic             clk_out
);
    logic             req1_q, req2_q;
    logic             byp1_q, byp2_q;
    logic [CNT_W-1:0] act_wait_q, act_hold_q;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    phase_t           ph_q, ph_d;
    logic             period_end;
    logic             load;
    logic             ack_q;

    // State register
    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= PH_HIGH;
            cnt_q <= '0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state and outputs
    always_comb begin
        ph_d       = ph_q;
        cnt_d      = cnt_q + 1'b1;
        period_end = 1'b0;
        unique case (ph_q)
            PH_HIGH: begin
                if (cnt_q == act_wait_q) begin
                    ph_d  = PH_LOW;
                    cnt_d = '0;
                end
            end
            PH_LOW: begin
                if (cnt_q == act_hold_q) begin
                    ph_d       = PH_HIGH;
                    cnt_d      = '0;
                    period_end = 1'b1;
                end
            end
        endcase
    end

    assign load = period_end & req2_q & ~ack_q;

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            req1_q     <= 1'b0;
            req2_q     <= 1'b0;
            byp1_q     <= 1'b1;
            byp2_q     <= 1'b1;
            act_wait_q <= '0;
            act_hold_q <= '0;
            ack_q      <= 1'b0;
        end else begin
            req1_q <= upd_req;
            req2_q <= req1_q;
            byp1_q <= cfg_byp;
            byp2_q <= byp1_q;
            if (load) begin
                act_wait_q <= cfg_wait;
                act_hold_q <= cfg_hold;
                ack_q      <= 1'b1;
            end else if (!req2_q) begin
                ack_q <= 1'b0;
            end
        end
    end

    assign upd_ack = ack_q;
    assign clk_out = byp2_q ? mclk : (ph_q == PH_HIGH);

    // R7
    upd_at_boundary_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        $rose(ack_q) |-> ($past(ph_q) == PH_LOW && ph_q == PH_HIGH));

    // R4
    counts_frozen_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        !$rose(ack_q) |-> $stable(act_wait_q) && $stable(act_hold_q));
endmodule

// File: rtl/clkdmn_cfg_regs.sv
module clkdmn_cfg_regs
    import clkdmn_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter bit FIXED_SRC = 1'b0,
    parameter int RST_SEL   = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_SRC-1:0] status_s,
    input  logic               upd_ack,
    output logic [NUM_SRC-1:0] tgt_oh,
    output logic [CNT_W-1:0]   cfg_wait,
    output logic [CNT_W-1:0]   cfg_hold,
    output logic               cfg_byp,
    output logic               upd_req
);
    logic [SEL_W-1:0] sel_q;
    logic [SEL_W-1:0] wr_sel;
    logic             wr_sel_ok;
    logic [CNT_W-1:0] wait_q, hold_q;
    logic             byp_q;
    logic             ack1_q, ack2_q;
    sel_state_t       sel_st_q, sel_st_d;
    upd_state_t       upd_st_q, upd_st_d;
    logic             sel_busy, upd_busy;
    logic             unused_wbits;

    assign wr_sel    = reg_wdata[SEL_LSB +: SEL_W];
    assign wr_sel_ok = reg_we && !FIXED_SRC && (wr_sel <= SEL_W'(NUM_SRC - 1));
    assign unused_wbits = ^reg_wdata;

    generate
        if (FIXED_SRC) begin : g_fixed
            assign sel_q = SEL_W'(FIX_SEL);
        end else begin : g_free
            logic [SEL_W-1:0] sel_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         sel_r <= SEL_W'(RST_SEL);
                else if (wr_sel_ok) sel_r <= wr_sel;
            end
            assign sel_q = sel_r;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q <= '0;
            hold_q <= '0;
            byp_q  <= 1'b1;
            ack1_q <= 1'b0;
            ack2_q <= 1'b0;
        end else begin
            ack1_q <= upd_ack;
            ack2_q <= ack1_q;
            if (reg_we) begin
                wait_q <= reg_wdata[WAIT_LSB +: CNT_W];
                hold_q <= reg_wdata[HOLD_LSB +: CNT_W];
                byp_q  <= reg_wdata[BYP_BIT];
            end
        end
    end

    // State registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_st_q <= SEL_STEADY;
            upd_st_q <= UPD_IDLE;
        end else begin
            sel_st_q <= sel_st_d;
            upd_st_q <= upd_st_d;
        end
    end

    // Transitions
    always_comb begin
        sel_st_d = sel_st_q;
        unique case (sel_st_q)
            SEL_STEADY: if (wr_sel_ok && wr_sel != sel_q) sel_st_d = SEL_SWITCH;
            SEL_SWITCH: if (status_s == tgt_oh)           sel_st_d = SEL_STEADY;
        endcase
        upd_st_d = upd_st_q;
        unique case (upd_st_q)
            UPD_IDLE:  if (reg_we && reg_wdata[UPD_BIT]) upd_st_d = UPD_REQ;
            UPD_REQ:   if (ack2_q)                       upd_st_d = UPD_DRAIN;
            UPD_DRAIN: if (!ack2_q)                      upd_st_d = UPD_IDLE;
            default:                                     upd_st_d = UPD_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        tgt_oh   = NUM_SRC'(1) << sel_q;
        sel_busy = (sel_st_q == SEL_SWITCH);
        upd_busy = (upd_st_q != UPD_IDLE);
        upd_req  = (upd_st_q == UPD_REQ);
        cfg_wait = wait_q;
        cfg_hold = hold_q;
        cfg_byp  = byp_q;
        reg_rdata = {6'b0, upd_busy, byp_q,
                     FLD_W'(hold_q), FLD_W'(wait_q),
                     12'b0, sel_busy, sel_q};
    end

    // R2
    bad_sel_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && wr_sel > SEL_W'(NUM_SRC - 1)) |=> $stable(sel_q));

    // R3
    sel_busy_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_st_q == SEL_STEADY && wr_sel_ok && wr_sel != sel_q) |=> reg_rdata[SBUSY_BIT]);

    // R6
    upd_busy_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_st_q == UPD_IDLE && reg_we && reg_wdata[UPD_BIT]) |=> reg_rdata[UPD_BIT]);

    // R6
    upd_busy_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_st_q == UPD_REQ && !ack2_q) |=> reg_rdata[UPD_BIT]);
endmodule

// File: rtl/clk_domain_gen.sv
module clk_domain_gen
    import clkdmn_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter bit FIXED_SRC = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  src_clk,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        clk_out
);
    localparam int RST_SEL = FIXED_SRC ? FIX_SEL : DEF_SEL;

    logic [NUM_SRC-1:0] tgt_oh;
    logic [NUM_SRC-1:0] status_s;
    logic [CNT_W-1:0]   cfg_wait, cfg_hold;
    logic               cfg_byp, upd_req, upd_ack, mclk;

    clkdmn_cfg_regs #(.CNT_W(CNT_W), .FIXED_SRC(FIXED_SRC), .RST_SEL(RST_SEL)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .status_s (status_s),
        .upd_ack  (upd_ack),
        .tgt_oh   (tgt_oh),
        .cfg_wait (cfg_wait),
        .cfg_hold (cfg_hold),
        .cfg_byp  (cfg_byp),
        .upd_req  (upd_req)
    );

    clkdmn_src_switch #(.NSRC(NUM_SRC), .RST_SEL(RST_SEL)) u_switch (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_clk (src_clk),
        .tgt_oh  (tgt_oh),
        .mclk    (mclk),
        .status_s(status_s)
    );

    clkdmn_divider #(.CNT_W(CNT_W)) u_div (
        .mclk    (mclk),
        .rst_n   (rst_n),
        .cfg_wait(cfg_wait),
        .cfg_hold(cfg_hold),
        .cfg_byp (cfg_byp),
        .upd_req (upd_req),
        .upd_ack (upd_ack),
        .clk_out (clk_out)
    );
endmodule

// File: tb/clk_domain_gen_tb_top.sv
`timescale 1ns/1ps
module clk_domain_gen_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s0 = 0, s1 = 0, s2 = 0, s3 = 0, s4 = 0;
    logic [4:0] src;
    logic we_m = 0, we_f = 0;
    logic [31:0] wd_m = '0, wd_f = '0;
    logic [31:0] rd_m, rd_f;
    logic out_m, out_f;
    logic [2:0] mon_idx = 3'd1;
    logic mon_fix = 1'b0;
    logic mon_clk, mon_out;
    int n_chk = 0, n_fail = 0;

    typedef struct packed { logic [5:0] hi; logic [5:0] lo; } per_t;
    per_t  exp_q[$];
    string tag_q[$];

    localparam logic [31:0] UPD = 32'h0200_0000;

    always #10 clk = ~clk;
    always #50 s0 = ~s0;
    always #19 s1 = ~s1;
    always #8  s2 = ~s2;
    always #13 s3 = ~s3;
    always #15 s4 = ~s4;
    assign src     = {s4, s3, s2, s1, s0};
    assign mon_clk = src[mon_idx];
    assign mon_out = mon_fix ? out_f : out_m;

    clk_domain_gen dut_i (
        .clk(clk), .rst_n(rst_n), .src_clk(src),
        .reg_we(we_m), .reg_wdata(wd_m), .reg_rdata(rd_m), .clk_out(out_m));

    clk_domain_gen #(.CNT_W(3), .FIXED_SRC(1'b1)) dut_fix_i (
        .clk(clk), .rst_n(rst_n), .src_clk(src),
        .reg_we(we_f), .reg_wdata(wd_f), .reg_rdata(rd_f), .clk_out(out_f));

    function automatic logic [31:0] mk(input int sel, input int w, input int h, input bit byp);
        return {6'b0, 1'b0, byp, 4'(h), 4'(w), 12'b0, 1'b0, 3'(sel)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit fx, input logic [31:0] d);
        @(negedge clk);
        if (fx) begin we_f = 1'b1; wd_f = d; end
        else    begin we_m = 1'b1; wd_m = d; end
        @(negedge clk);
        we_f = 1'b0;
        we_m = 1'b0;
    endtask

    task automatic poll_clear(input bit fx, input int bitpos, input string tag);
        for (int i = 0; i < 4000; i++) begin
            if (!(fx ? rd_f[bitpos] : rd_m[bitpos])) break;
            @(negedge clk);
        end
        check(tag, 32'(fx ? rd_f[bitpos] : rd_m[bitpos]), 32'd0);
    endtask

    // Driver side of the scoreboard
    task automatic expect_period(input int hi, input int lo, input string tag);
        exp_q.push_back('{hi: 6'(hi), lo: 6'(lo)});
        tag_q.push_back(tag);
    endtask

    // Monitor side: measure one full high/low run at falling source edges
    task automatic monitor_pop();
        per_t  e;
        string t;
        int    hi, lo;
        logic  prev, cur;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        prev = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge mon_clk);
            cur = mon_out;
            if (!prev && cur) break;
            prev = cur;
        end
        hi = 1;
        for (int i = 0; i < 100; i++) begin
            @(negedge mon_clk);
            if (mon_out) hi++; else break;
        end
        lo = 1;
        for (int i = 0; i < 100; i++) begin
            @(negedge mon_clk);
            if (!mon_out) lo++; else break;
        end
        check({t, " high"}, 32'(hi), 32'(e.hi));
        check({t, " low"},  32'(lo), 32'(e.lo));
    endtask

    task automatic bypass_follow(input string tag);
        for (int i = 0; i < 3; i++) begin
            @(posedge mon_clk); #2;
            check({tag, " src high"}, 32'(mon_out), 32'd1);
            @(negedge mon_clk); #2;
            check({tag, " src low"}, 32'(mon_out), 32'd0);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #3_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, R10 fixed variant reset select
        check("R1 reset word", rd_m, 32'h0100_0001);
        check("R10 fixed reset word", rd_f, 32'h0100_0004);

        // R5 bypass follows oscillator
        mon_idx = 3'd1;
        bypass_follow("R5 bypass");

        // R6 update request, R4 asymmetric split
        wr(0, mk(1, 2, 4, 0) | UPD);
        check("R6 busy after request", 32'(rd_m[25]), 32'd1);
        poll_clear(0, 25, "R6 self clear");
        check("R6 word after update", rd_m, mk(1, 2, 4, 0));
        expect_period(3, 5, "R4 wait2 hold4");
        monitor_pop();

        // R7 counts without request do not apply
        wr(0, mk(1, 5, 5, 0));
        check("R7 counts stored", rd_m, mk(1, 5, 5, 0));
        expect_period(3, 5, "R7 old period kept");
        monitor_pop();

        // R8 even ratio 12 gives 6/6
        wr(0, mk(1, 5, 5, 0) | UPD);
        poll_clear(0, 25, "R8 update done");
        expect_period(6, 6, "R8 ratio 12");
        monitor_pop();

        // R2 invalid select ignored
        wr(0, mk(6, 5, 5, 0));
        check("R2 select kept", rd_m, mk(1, 5, 5, 0));
        expect_period(6, 6, "R2 output unchanged");
        monitor_pop();

        // R3 switch to source 3, R11 clean handover
        wr(0, mk(3, 5, 5, 0));
        check("R3 busy raised", 32'(rd_m[3]), 32'd1);
        poll_clear(0, 3, "R3 busy cleared");
        check("R3 word after switch", rd_m, mk(3, 5, 5, 0));
        mon_idx = 3'd3;
        expect_period(6, 6, "R3 R11 period on source 3");
        monitor_pop();

        // R4 minimum ratio on slow source 0
        wr(0, mk(0, 5, 5, 0));
        poll_clear(0, 3, "R3 switch to source 0");
        wr(0, mk(0, 0, 0, 0) | UPD);
        poll_clear(0, 25, "R6 update min ratio");
        mon_idx = 3'd0;
        expect_period(1, 1, "R4 ratio 2");
        monitor_pop();

        // R4 maximum ratio on source 2
        wr(0, mk(2, 0, 0, 0));
        poll_clear(0, 3, "R3 switch to source 2");
        wr(0, mk(2, 15, 15, 0) | UPD);
        poll_clear(0, 25, "R6 update max ratio");
        mon_idx = 3'd2;
        expect_period(16, 16, "R4 ratio 32");
        monitor_pop();

        // R5 bypass again on source 2
        wr(0, mk(2, 15, 15, 1));
        repeat (4) @(negedge clk);
        bypass_follow("R5 bypass source 2");

        // R10 fixed variant ignores select, R9 narrow fields
        wr(1, mk(2, 7, 3, 0) | UPD);
        check("R10 select reads 4", 32'(rd_f[2:0]), 32'd4);
        poll_clear(1, 25, "R6 fixed update");
        check("R10 fixed word", rd_f, mk(4, 7, 3, 0));
        mon_fix = 1'b1;
        mon_idx = 3'd4;
        expect_period(8, 4, "R10 R9 period on source 4");
        monitor_pop();
        wr(1, mk(2, 15, 15, 0));
        check("R9 upper bit masked", rd_f, mk(4, 7, 7, 0));

        finish_run();
    end
endmodule